// File: doc/BRIEF.md
# Banked GPIO Controller with Shared Interrupt

This block is a register-mapped general-purpose I/O controller. Its pins are split into banks of 32 lines. Every bank has eight 32-bit registers. Software uses them to set each pin's direction, output value and open-drain behaviour, and to choose how the pin raises an interrupt. A pin can trigger on a rising edge, on a falling edge, on both edges, or on a high or low level.

External pins pass through a two-stage synchronizer. Per-pin trigger logic then sets a sticky status bit, which software clears by writing a one to it. Each status bit is gated by its mask bit. The gated bits of every bank are ORed into a single interrupt line. A bank can be built with fewer than 32 real lines. The unused upper lines are inert: they read as zero, never drive a pin and never raise status.

Top module: `gpio_banked`

## Requirements
- R1: The byte address selects the bank in bits [ADDR_W-1:5] and the register in bits [4:2]. The register indices are: 0 open-drain enable, 1 data, 2 direction, 3 edge/level polarity, 4 both-edge select, 5 mask, 6 level mode, 7 status. A read returns its value on rdata_o one cycle after the request.
- R2: After reset, the mask, data, open-drain, polarity, both-edge, level and status registers read 0, every valid direction bit reads 1 (input), and irq_o is low.
- R3: A direction bit of 0 makes the line an output: pin_oe_o is 1 and pin_o equals the data bit. Reading the data register returns the data bit for output lines and the synchronized pin for input lines.
- R4: For an output line whose open-drain bit is 1, pin_oe_o is 1 only while the data bit is 0.
- R5: With level mode 0 and both-edge 0, a polarity bit of 1 sets status on a rising edge and a polarity bit of 0 sets status on a falling edge.
- R6: A both-edge bit of 1 (with level mode 0) sets status on rising and falling edges, whatever the polarity bit is.
- R7: With level mode 1, status is set on every cycle in which the synchronized pin equals the polarity bit (1 = high, 0 = low). A clear therefore has no lasting effect while the level persists.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a trigger and a clear hit the same bit in the same cycle, the bit stays set.
- R9: Status bits latch events even when masked. irq_o is the OR over all banks of status AND mask.
- R10: Lines at or above a bank's configured width read 0 in every register, ignore writes, never set status and never enable their output.
- R11: A pin change driven before clock edge E0 shows up in status (and irq_o) after edge E2, and not after E1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address (bank, register) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| pin_i | input | NUM_BANKS*32 | Asynchronous pin inputs |
| pin_o | output | NUM_BANKS*32 | Pin output values |
| pin_oe_o | output | NUM_BANKS*32 | Pin output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a status bit that is set by a new edge in exactly the same cycle that software writes a one to clear it. Seen from the pins, this depends on the synchronizer depth, so the stimulus counts edges precisely. It changes the pin, lets two clock edges pass, and then issues the clearing write so that it commits on the edge where the trigger fires. The bit must still read set afterwards. A second timing case uses irq_o to show that status becomes visible after the third edge and not the second. Level mode is checked by clearing while the level is still active and confirming the bit comes straight back.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned LINES  = 32;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_ODRAIN = 3'd0,
    REG_DATA   = 3'd1,
    REG_DIR    = 3'd2,
    REG_POL    = 3'd3,
    REG_BOTH   = 3'd4,
    REG_MASK   = 3'd5,
    REG_LVL    = 3'd6,
    REG_STAT   = 3'd7
  } reg_idx_e;

  function automatic logic [LINES-1:0] width_mask(int unsigned w);
    logic [LINES-1:0] m;
    for (int i = 0; i < LINES; i++) m[i] = (i < w);
    return m;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] rise, fall, edge_hit, lvl_hit;

  assign rise     = cur_i & ~prev_i;
  assign fall     = ~cur_i & prev_i;
  // both-edge overrides polarity
  assign edge_hit = (both_i & (rise | fall)) | (~both_i & ((pol_i & rise) | (~pol_i & fall)));
  assign lvl_hit  = ~(cur_i ^ pol_i);
  assign hit_o    = (lvl_i & lvl_hit) | (~lvl_i & edge_hit);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] reg_sel_i,
  input  logic [LINES-1:0]  wdata_i,
  input  logic [LINES-1:0]  pin_i,
  output logic [LINES-1:0]  rd_o,
  output logic [LINES-1:0]  pin_o,
  output logic [LINES-1:0]  pin_oe_o,
  output logic [LINES-1:0]  stat_o,
  output logic [LINES-1:0]  mask_o,
  output logic [LINES-1:0]  dir_o,
  output logic [LINES-1:0]  od_o,
  output logic              irq_o
);
  localparam logic [LINES-1:0] VALID = width_mask(WIDTH);

  logic [LINES-1:0] od_q, data_q, dir_q, pol_q, both_q, mask_q, lvl_q, stat_q;
  logic [LINES-1:0] cur, prev_q, hit, clr, wd;

  gpio_sync #(.W(LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (cur)
  );

  gpio_trig #(.W(LINES)) u_trig (
    .cur_i (cur),
    .prev_i(prev_q),
    .pol_i (pol_q),
    .both_i(both_q),
    .lvl_i (lvl_q),
    .hit_o (hit)
  );

  assign wd  = wdata_i & VALID;
  assign clr = (wr_en_i && reg_sel_i == REG_STAT) ? wd : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      od_q   <= '0;
      data_q <= '0;
      dir_q  <= VALID;
      pol_q  <= '0;
      both_q <= '0;
      mask_q <= '0;
      lvl_q  <= '0;
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= cur;
      // a trigger in the clearing cycle survives
      stat_q <= ((stat_q & ~clr) | hit) & VALID;
      if (wr_en_i) begin
        unique case (reg_sel_i)
          REG_ODRAIN: od_q   <= wd;
          REG_DATA:   data_q <= wd;
          REG_DIR:    dir_q  <= wd;
          REG_POL:    pol_q  <= wd;
          REG_BOTH:   both_q <= wd;
          REG_MASK:   mask_q <= wd;
          REG_LVL:    lvl_q  <= wd;
          default:    ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (reg_sel_i)
      REG_ODRAIN: rd_o = od_q;
      REG_DATA:   rd_o = ((dir_q & cur) | (~dir_q & data_q)) & VALID;
      REG_DIR:    rd_o = dir_q;
      REG_POL:    rd_o = pol_q;
      REG_BOTH:   rd_o = both_q;
      REG_MASK:   rd_o = mask_q;
      REG_LVL:    rd_o = lvl_q;
      default:    rd_o = stat_q;
    endcase
  end

  assign pin_o    = data_q;
  assign pin_oe_o = ~dir_q & VALID & (~od_q | ~data_q);
  assign stat_o   = stat_q;
  assign mask_o   = mask_q;
  assign dir_o    = dir_q;
  assign od_o     = od_q;
  assign irq_o    = |(stat_q & mask_q);
endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter logic [NUM_BANKS*6-1:0] BANK_WIDTHS = {6'd20, 6'd32},
  parameter int unsigned BANK_AW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  parameter int unsigned ADDR_W = BANK_AW + 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  input  logic [NUM_BANKS*32-1:0] pin_i,
  output logic [NUM_BANKS*32-1:0] pin_o,
  output logic [NUM_BANKS*32-1:0] pin_oe_o,
  output logic                   irq_o
);
  localparam int unsigned PINS = NUM_BANKS * LINES;

  logic [BANK_AW-1:0] bank_idx;
  logic [REG_AW-1:0]  reg_idx;
  logic               bank_ok;
  logic [1:0]         unused_byte;
  logic [LINES-1:0]   rd_bank [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq;
  logic [PINS-1:0]    stat_all, mask_all, dir_all, od_all, valid_all;
  logic [31:0]        rdata_q;

  assign bank_idx    = addr_i[ADDR_W-1:5];
  assign reg_idx     = addr_i[4:2];
  assign unused_byte = addr_i[1:0];
  assign bank_ok     = 32'(bank_idx) < NUM_BANKS;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_en;
    assign wr_en = req_i & we_i & bank_ok & (bank_idx == BANK_AW'(b));
    assign valid_all[b*LINES +: LINES] = width_mask(32'(BANK_WIDTHS[b*6 +: 6]));

    gpio_bank #(.WIDTH(32'(BANK_WIDTHS[b*6 +: 6]))) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en),
      .reg_sel_i(reg_idx),
      .wdata_i  (wdata_i),
      .pin_i    (pin_i[b*LINES +: LINES]),
      .rd_o     (rd_bank[b]),
      .pin_o    (pin_o[b*LINES +: LINES]),
      .pin_oe_o (pin_oe_o[b*LINES +: LINES]),
      .stat_o   (stat_all[b*LINES +: LINES]),
      .mask_o   (mask_all[b*LINES +: LINES]),
      .dir_o    (dir_all[b*LINES +: LINES]),
      .od_o     (od_all[b*LINES +: LINES]),
      .irq_o    (bank_irq[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= bank_ok ? rd_bank[bank_idx] : '0;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |bank_irq;
endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W = 6
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_i,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [NUM_BANKS*32-1:0] pin_o,
  input logic [NUM_BANKS*32-1:0] pin_oe_o,
  input logic                    irq_o,
  input logic [NUM_BANKS*32-1:0] stat_all,
  input logic [NUM_BANKS*32-1:0] mask_all,
  input logic [NUM_BANKS*32-1:0] dir_all,
  input logic [NUM_BANKS*32-1:0] od_all,
  input logic [NUM_BANKS*32-1:0] valid_all
);
  logic stat_wr;
  assign stat_wr = req_i & we_i & (addr_i[4:2] == 3'd7);

  a_r9_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(stat_all & mask_all)));

  a_r8_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(stat_wr) |-> (($past(stat_all) & ~stat_all) == '0));

  a_r10_invalid_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_all | pin_oe_o) & ~valid_all) == '0);

  a_r3_oe_only_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & dir_all) == '0);

  a_r4_od_no_high_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & pin_o & od_all) == '0);
endmodule

bind gpio_banked gpio_banked_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .irq_o    (irq_o),
  .stat_all (stat_all),
  .mask_all (mask_all),
  .dir_all  (dir_all),
  .od_all   (od_all),
  .valid_all(valid_all)
);

// File: tb/gpio_banked_tb.sv
`timescale 1ns/1ps
module gpio_banked_tb;
  localparam int NB = 2;
  localparam int AW = 6;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NB*32-1:0] pin = '0, pout, poe;
  logic irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  gpio_banked #(.NUM_BANKS(NB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .pin_o(pout),
    .pin_oe_o(poe), .irq_o(irq)
  );

  function automatic logic [AW-1:0] ad(int b, int r);
    return AW'(b * 32 + r * 4);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(int b, int r, logic [31:0] d);
    req = 1; we = 1; addr = ad(b, r); wdata = d;
    @(posedge clk); @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd_chk(int b, int r, logic [31:0] exp, string tag);
    req = 1; we = 0; addr = ad(b, r);
    @(posedge clk); @(negedge clk);
    req = 0;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic quiesce();
    pin = '0; tick(4);
    for (int b = 0; b < NB; b++) begin
      wr(b, 3, 0); wr(b, 4, 0); wr(b, 5, 0); wr(b, 6, 0); wr(b, 7, 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_reset();
    rd_chk(0, 2, 32'hFFFF_FFFF, "R2 dir bank0");
    rd_chk(1, 2, 32'h000F_FFFF, "R2/R10 dir bank1");
    rd_chk(0, 5, 0, "R2 mask");
    rd_chk(1, 7, 0, "R2 status");
    chk(irq === 1'b0, "R2 irq", 32'(irq), 0);
    chk(poe === '0, "R2 oe", poe[31:0], 0);
  endtask

  task automatic t_dir_od();
    wr(0, 2, 32'hFFFF_FF00);
    wr(0, 1, 32'h0000_00A5);
    chk(poe[7:0] === 8'hFF, "R3 oe", 32'(poe[7:0]), 32'hFF);
    chk(pout[7:0] === 8'hA5, "R3 pin_o", 32'(pout[7:0]), 32'hA5);
    pin[15:8] = 8'h3C; tick(3);
    rd_chk(0, 1, 32'h0000_3CA5, "R3 data read mix");
    wr(0, 0, 32'h0000_00FF);
    chk(poe[7:0] === 8'h5A, "R4 open drain", 32'(poe[7:0]), 32'h5A);
    wr(0, 0, 0); wr(0, 2, 32'hFFFF_FFFF); wr(0, 1, 0);
    quiesce();
  endtask

  task automatic t_edges();
    wr(0, 3, 32'h0000_0001);
    pin[1:0] = 2'b11; tick(4);
    rd_chk(0, 7, 32'h1, "R5 rising only");
    wr(0, 7, 32'h1);
    pin[1:0] = 2'b00; tick(4);
    rd_chk(0, 7, 32'h2, "R5 falling only");
    quiesce();
    wr(0, 4, 32'h0000_0004); wr(0, 3, 32'h0000_0004);
    pin[2] = 1; tick(4);
    rd_chk(0, 7, 32'h4, "R6 both rise");
    wr(0, 7, 32'h4);
    pin[2] = 0; tick(4);
    rd_chk(0, 7, 32'h4, "R6 both fall");
    quiesce();
  endtask

  task automatic t_level();
    wr(0, 3, 32'h0000_0008); wr(0, 6, 32'h0000_0018);
    tick(2);
    rd_chk(0, 7, 32'h10, "R7 low level active");
    pin[3] = 1; tick(4);
    wr(0, 7, 32'h18);
    rd_chk(0, 7, 32'h18, "R7 level reasserts after clear");
    pin[3] = 1'b0; pin[4] = 1'b1; tick(4);
    wr(0, 7, 32'h18);
    rd_chk(0, 7, 32'h0, "R7 inactive clears");
    quiesce();
  endtask

  task automatic t_w1c();
    wr(0, 3, 32'h0000_0020);
    pin[5] = 1; tick(4);
    wr(0, 7, 32'h0);
    rd_chk(0, 7, 32'h20, "R8 write zero keeps");
    pin[5] = 0; tick(4);
    wr(0, 7, 32'h20);
    rd_chk(0, 7, 32'h0, "R8 write one clears");
    pin[5] = 1; tick(4);
    pin[5] = 0; tick(4);
    pin[5] = 1; tick(2);
    wr(0, 7, 32'h20);
    rd_chk(0, 7, 32'h20, "R8 edge beats clear");
    quiesce();
  endtask

  task automatic t_mask_irq();
    wr(0, 3, 32'h1); wr(1, 3, 32'h1);
    pin[0] = 1; pin[32] = 1; tick(4);
    chk(irq === 1'b0, "R9 masked no irq", 32'(irq), 0);
    rd_chk(0, 7, 32'h1, "R9 status latched while masked");
    wr(0, 5, 32'h1);
    chk(irq === 1'b1, "R9 irq after unmask", 32'(irq), 1);
    wr(1, 5, 32'h1); wr(0, 7, 32'h1);
    chk(irq === 1'b1, "R9 irq from bank1", 32'(irq), 1);
    wr(1, 7, 32'h1);
    chk(irq === 1'b0, "R9 irq drops", 32'(irq), 0);
    quiesce();
  endtask

  task automatic t_invalid();
    wr(1, 4, 32'hFFFF_FFFF); wr(1, 5, 32'hFFFF_FFFF); wr(1, 2, 32'h0);
    rd_chk(1, 5, 32'h000F_FFFF, "R10 mask upper zero");
    chk(poe[63:52] === '0, "R10 oe upper", 32'(poe[63:52]), 0);
    wr(1, 2, 32'hFFFF_FFFF); wr(1, 7, 32'hFFFF_FFFF);
    pin[57] = 1; tick(4); pin[57] = 0; tick(4);
    rd_chk(1, 7, 32'h0, "R10 no upper status");
    chk(irq === 1'b0, "R10 no irq", 32'(irq), 0);
    quiesce();
  endtask

  task automatic t_latency();
    wr(0, 3, 32'h40); wr(0, 5, 32'h40);
    pin[6] = 1; tick(2);
    chk(irq === 1'b0, "R11 not after E1", 32'(irq), 0);
    tick(1);
    chk(irq === 1'b1, "R11 set after E2", 32'(irq), 1);
    rd_chk(0, 7, 32'h40, "R1 status index 7");
    quiesce();
  endtask

  initial begin
    tick(3); rst_n = 1; tick(1);
    t_reset();
    t_dir_od();
    t_edges();
    t_level();
    t_w1c();
    t_mask_irq();
    t_invalid();
    t_latency();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule